// File: doc/BRIEF.md
# Serial Receive Frame FIFO with Threshold and Error Tracking

This block buffers received serial frames between an asynchronous receiver and the register side of a serial port. Each accepted frame is stored with nine data bits, its multiprocessor bit and its own parity and framing error bits. The oldest frame is always presented at the head outputs, and a read strobe for the low part of that frame removes it.

Around the store, the block derives the status a driver needs. It reports the fill level and a flag that compares the fill level against a programmable receive threshold. It keeps counts of the buffered frames that carry framing and parity errors. It raises a data-ready flag when the line has been idle for a while and a few frames are left below the threshold. It raises a sticky overrun flag when a frame arrives with no free slot. A flow-control output drops once the fill level reaches its own threshold. A select decides whether the data-ready event is signalled on the receive request or on the error request.

Top module: `rx_frame_fifo`

## Requirements
- R1: `count_o` gives the number of stored frames, 0 to DEPTH (16 by default). An accepted frame adds one, a pop removes one, and both in the same cycle leave the count unchanged.
- R2: Frames leave in arrival order. `head_data_o`, `head_mpb_o`, `head_perr_o` and `head_ferr_o` show the oldest stored frame and are all zero when the FIFO is empty. The high part is meant to be read first, because the `rd_lo_i` strobe (the low-part read) pops the head.
- R3: `trig_full_o` is 1 when `count_o` is greater than or equal to `rtrg_i`, and 0 otherwise.
- R4: `ferr_cnt_o` and `perr_cnt_o` give the number of stored frames whose framing or parity error bit is set. They follow pushes and pops, so they never exceed `count_o`.
- R5: `dready_o` sets on the IDLE_BITS-th (15th by default) `bit_tick_i` pulse counted after the last accepted frame, provided no `start_det_i` arrived in between and 0 < `count_o` <= `rtrg_i` at that pulse. It clears on `start_det_i`, on an accepted frame, on the pop that empties the FIFO, and on `fifo_clr_i`. It is never 1 while the FIFO is empty.
- R6: A frame offered while `count_o` equals DEPTH is discarded and sets `ovr_o`. `ovr_o` stays set until `ovr_clr_i` is pulsed, and a new overrun in the clearing cycle wins.
- R7: `fifo_clr_i` empties the FIFO. On the next cycle `count_o`, both error counts and `dready_o` are 0, while `ovr_o` keeps its value.
- R8: With `dres_sel_i`=0, `rx_irq_o` = `trig_full_o` | `dready_o` and `err_irq_o` = `ovr_o`. With `dres_sel_i`=1, `rx_irq_o` = `trig_full_o` and `err_irq_o` = `ovr_o` | `dready_o`.
- R9: `rts_o` is 1 while `count_o` < `rts_trg_i` and 0 once `count_o` >= `rts_trg_i`.
- R10: A stored frame keeps all nine data bits and the multiprocessor bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_clr_i | input | 1 | Empties the FIFO |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rtrg_i | input | 5 | Receive threshold |
| rts_trg_i | input | 5 | Flow-control threshold |
| dres_sel_i | input | 1 | Routes data-ready: 0 receive request, 1 error request |
| wr_valid_i | input | 1 | Frame from receiver valid |
| wr_data_i | input | 9 | Frame data bits |
| wr_mpb_i | input | 1 | Frame multiprocessor bit |
| wr_perr_i | input | 1 | Frame parity error |
| wr_ferr_i | input | 1 | Frame framing error |
| start_det_i | input | 1 | Start bit detected on the line |
| bit_tick_i | input | 1 | One pulse per bit period |
| rd_lo_i | input | 1 | Low-part read strobe, pops the head |
| head_data_o | output | 9 | Head frame data |
| head_mpb_o | output | 1 | Head frame multiprocessor bit |
| head_perr_o | output | 1 | Head frame parity error |
| head_ferr_o | output | 1 | Head frame framing error |
| count_o | output | 5 | Stored frame count |
| ferr_cnt_o | output | 5 | Stored frames with framing error |
| perr_cnt_o | output | 5 | Stored frames with parity error |
| trig_full_o | output | 1 | Count at or above receive threshold |
| dready_o | output | 1 | Idle data-ready flag |
| ovr_o | output | 1 | Sticky overrun flag |
| rts_o | output | 1 | Flow control, high while room remains |
| rx_irq_o | output | 1 | Receive request |
| err_irq_o | output | 1 | Error request |

## Verification
All state registers once. The count, head fields, error counts and overrun flag therefore change on the first rising edge after a push, pop, clear or overrun stimulus. The threshold flags, the flow-control output and the request outputs are combinational from that state, so they are due in the same cycle. The data-ready flag is due on the edge that samples the 15th bit tick. The bench changes inputs on falling edges and checks each result at the falling edge after the rising edge that produces it, and it checks the data-ready flag both one tick before that edge and at it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_DATA_W = 9;

  typedef struct packed {
    logic                  ferr;
    logic                  perr;
    logic                  mpb;
    logic [RXF_DATA_W-1:0] data;
  } rxf_entry_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       ovr_clr_i,
  input  logic       push_req_i,
  input  rxf_entry_t entry_i,
  input  logic       pop_req_i,
  output rxf_entry_t head_o,
  output logic [CW-1:0] count_o,
  output logic       pushed_o,
  output logic       popped_o,
  output logic       ovr_o
);
  rxf_entry_t      mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]   count_q;
  logic            ovr_q;
  logic            full, empty, drop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign pushed_o = push_req_i && !full && !clr_i;
  assign popped_o = pop_req_i && !empty && !clr_i;
  assign drop     = push_req_i && full && !clr_i;

  always_ff @(posedge clk_i) begin
    if (pushed_o) mem_q[wr_ptr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (pushed_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (popped_o) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({pushed_o, popped_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // overrun survives a FIFO clear; a new drop beats the clear strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (drop)      ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end

  assign head_o  = empty ? '0 : mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign ovr_o   = ovr_q;

  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)) else $error("count above depth"); // R1
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q == '0)) else $error("clear left data"); // R7
  AST_DROP_SETS_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req_i && full && !clr_i) |=> ovr_q) else $error("drop without overrun"); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr_i) |=> ovr_q) else $error("overrun lost"); // R6
  AST_FULL_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop_req_i) |=> (count_q == CW'(DEPTH)) || $past(clr_i)) else $error("count grew past full"); // R1
endmodule

// File: rtl/rxf_err_cnt.sv
module rxf_err_cnt #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  AST_ERR_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i) |-> (cnt_q != '0)) else $error("error count underflow"); // R4
endmodule

// File: rtl/rxf_idle.sv
module rxf_idle #(
  parameter int unsigned IDLE_BITS = 15,
  parameter int unsigned CW        = 5,
  localparam int unsigned TW       = $clog2(IDLE_BITS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          frame_i,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          pop_last_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] rtrg_i,
  output logic          dready_o
);
  logic          armed_q, dready_q;
  logic [TW-1:0] idle_q;
  logic          expire, qualify;

  assign expire  = armed_q && tick_i && (idle_q == TW'(IDLE_BITS - 1));
  assign qualify = (count_i != '0) && (count_i <= rtrg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      idle_q  <= '0;
    end else if (clr_i || start_i) begin
      armed_q <= 1'b0;
      idle_q  <= '0;
    end else if (frame_i) begin
      armed_q <= 1'b1;
      idle_q  <= '0;
    end else if (expire) begin
      armed_q <= 1'b0;
      idle_q  <= '0;
    end else if (armed_q && tick_i) begin
      idle_q  <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       dready_q <= 1'b0;
    else if (clr_i || start_i || frame_i || pop_last_i) dready_q <= 1'b0;
    else if (expire && qualify)                        dready_q <= 1'b1;
  end

  assign dready_o = dready_q;

  AST_START_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !dready_q) else $error("ready survived start bit"); // R5
  AST_READY_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dready_q |-> (count_i != '0)) else $error("ready while empty"); // R5
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned IDLE_BITS = 15,
  localparam int unsigned CW       = $clog2(DEPTH + 1),
  localparam int unsigned DW       = RXF_DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_clr_i,
  input  logic          ovr_clr_i,
  input  logic [CW-1:0] rtrg_i,
  input  logic [CW-1:0] rts_trg_i,
  input  logic          dres_sel_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_mpb_i,
  input  logic          wr_perr_i,
  input  logic          wr_ferr_i,
  input  logic          start_det_i,
  input  logic          bit_tick_i,
  input  logic          rd_lo_i,
  output logic [DW-1:0] head_data_o,
  output logic          head_mpb_o,
  output logic          head_perr_o,
  output logic          head_ferr_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] ferr_cnt_o,
  output logic [CW-1:0] perr_cnt_o,
  output logic          trig_full_o,
  output logic          dready_o,
  output logic          ovr_o,
  output logic          rts_o,
  output logic          rx_irq_o,
  output logic          err_irq_o
);
  localparam int unsigned NERR = 2;  // 0: framing, 1: parity

  rxf_entry_t    wr_entry, head;
  logic [CW-1:0] count;
  logic          pushed, popped;
  logic [NERR-1:0] in_err, head_err;
  logic [CW-1:0] err_cnt [NERR];

  assign wr_entry = '{ferr: wr_ferr_i, perr: wr_perr_i, mpb: wr_mpb_i, data: wr_data_i};

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (fifo_clr_i),
    .ovr_clr_i  (ovr_clr_i),
    .push_req_i (wr_valid_i),
    .entry_i    (wr_entry),
    .pop_req_i  (rd_lo_i),
    .head_o     (head),
    .count_o    (count),
    .pushed_o   (pushed),
    .popped_o   (popped),
    .ovr_o      (ovr_o)
  );

  assign in_err   = {wr_entry.perr, wr_entry.ferr};
  assign head_err = {head.perr, head.ferr};

  for (genvar g = 0; g < NERR; g++) begin : g_err
    rxf_err_cnt #(.CW(CW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (fifo_clr_i),
      .inc_i  (pushed && in_err[g]),
      .dec_i  (popped && head_err[g]),
      .cnt_o  (err_cnt[g])
    );
  end

  rxf_idle #(.IDLE_BITS(IDLE_BITS), .CW(CW)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (fifo_clr_i),
    .frame_i    (pushed),
    .start_i    (start_det_i),
    .tick_i     (bit_tick_i),
    .pop_last_i (popped && (count == CW'(1)) && !pushed),
    .count_i    (count),
    .rtrg_i     (rtrg_i),
    .dready_o   (dready_o)
  );

  assign head_data_o = head.data;
  assign head_mpb_o  = head.mpb;
  assign head_perr_o = head.perr;
  assign head_ferr_o = head.ferr;
  assign count_o     = count;
  assign ferr_cnt_o  = err_cnt[0];
  assign perr_cnt_o  = err_cnt[1];
  assign trig_full_o = (count >= rtrg_i);
  assign rts_o       = (count < rts_trg_i);
  assign rx_irq_o    = trig_full_o | (dready_o & ~dres_sel_i);
  assign err_irq_o   = ovr_o | (dready_o & dres_sel_i);

  AST_FERR_WITHIN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_cnt_o <= count) else $error("framing count above fill"); // R4
  AST_PERR_WITHIN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_cnt_o <= count) else $error("parity count above fill"); // R4
  AST_HEAD_ZERO_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0) |-> (head_data_o == '0 && !head_mpb_o && !head_perr_o && !head_ferr_o))
    else $error("head not blank when empty"); // R2
endmodule

// File: tb/rx_frame_fifo_bench.sv
module rx_frame_fifo_bench;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_clr_i = 0, ovr_clr_i = 0, dres_sel_i = 0;
  logic [CW-1:0] rtrg_i = 5'd4, rts_trg_i = 5'd6;
  logic wr_valid_i = 0, wr_mpb_i = 0, wr_perr_i = 0, wr_ferr_i = 0;
  logic [8:0] wr_data_i = '0;
  logic start_det_i = 0, bit_tick_i = 0, rd_lo_i = 0;
  logic [8:0] head_data_o;
  logic head_mpb_o, head_perr_o, head_ferr_o;
  logic [CW-1:0] count_o, ferr_cnt_o, perr_cnt_o;
  logic trig_full_o, dready_o, ovr_o, rts_o, rx_irq_o, err_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_frame_fifo u_rx_frame_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_clr_i(fifo_clr_i), .ovr_clr_i(ovr_clr_i),
    .rtrg_i(rtrg_i), .rts_trg_i(rts_trg_i), .dres_sel_i(dres_sel_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_mpb_i(wr_mpb_i),
    .wr_perr_i(wr_perr_i), .wr_ferr_i(wr_ferr_i), .start_det_i(start_det_i),
    .bit_tick_i(bit_tick_i), .rd_lo_i(rd_lo_i), .head_data_o(head_data_o),
    .head_mpb_o(head_mpb_o), .head_perr_o(head_perr_o), .head_ferr_o(head_ferr_o),
    .count_o(count_o), .ferr_cnt_o(ferr_cnt_o), .perr_cnt_o(perr_cnt_o),
    .trig_full_o(trig_full_o), .dready_o(dready_o), .ovr_o(ovr_o), .rts_o(rts_o),
    .rx_irq_o(rx_irq_o), .err_irq_o(err_irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: inputs already set after a falling edge, result sampled at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic push(input logic [8:0] d, input logic m, input logic pe, input logic fe);
    wr_valid_i = 1; wr_data_i = d; wr_mpb_i = m; wr_perr_i = pe; wr_ferr_i = fe;
    step();
    wr_valid_i = 0;
  endtask

  task automatic pop();
    rd_lo_i = 1; step(); rd_lo_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick_i = 1; step(); bit_tick_i = 0;
    end
  endtask

  task automatic t_reset();
    chk("R1 reset count", count_o, 0);
    chk("R4 reset ferr", ferr_cnt_o, 0);
    chk("R6 reset ovr", ovr_o, 0);
    chk("R5 reset dready", dready_o, 0);
    chk("R9 reset rts", rts_o, 1);
    chk("R3 reset trig", trig_full_o, 0);
  endtask

  task automatic t_order();
    push(9'h1A5, 1, 0, 1);
    push(9'h03C, 0, 1, 0);
    push(9'h100, 1, 1, 1);
    chk("R1 count 3", count_o, 3);
    chk("R4 ferr 2", ferr_cnt_o, 2);
    chk("R4 perr 2", perr_cnt_o, 2);
    chk("R10 head data", head_data_o, 'h1A5);
    chk("R10 head mpb", head_mpb_o, 1);
    chk("R2 head perr", head_perr_o, 0);
    chk("R2 head ferr", head_ferr_o, 1);
    pop();
    chk("R2 second data", head_data_o, 'h03C);
    chk("R2 second perr", head_perr_o, 1);
    chk("R4 ferr after pop", ferr_cnt_o, 1);
    chk("R4 perr after pop", perr_cnt_o, 2);
    pop();
    chk("R10 third data bit8", head_data_o, 'h100);
    chk("R4 perr 1", perr_cnt_o, 1);
    pop();
    chk("R1 empty", count_o, 0);
    chk("R2 head blank", head_data_o, 0);
    chk("R4 ferr zero", ferr_cnt_o, 0);
    chk("R4 perr zero", perr_cnt_o, 0);
    pop();
    chk("R1 pop empty no wrap", count_o, 0);
  endtask

  task automatic t_thresholds();
    for (int i = 0; i < 3; i++) push(9'(i), 0, 0, 0);
    chk("R3 below trig", trig_full_o, 0);
    push(9'h3, 0, 0, 0);
    chk("R3 at trig", trig_full_o, 1);
    chk("R8 rx irq from trig", rx_irq_o, 1);
    push(9'h4, 0, 0, 0);
    chk("R9 rts at 5", rts_o, 1);
    push(9'h5, 0, 0, 0);
    chk("R9 rts at 6", rts_o, 0);
    for (int i = 0; i < 6; i++) pop();
    chk("R1 drained", count_o, 0);
    chk("R9 rts back", rts_o, 1);
  endtask

  task automatic t_same_cycle();
    push(9'h011, 0, 0, 0);
    wr_valid_i = 1; wr_data_i = 9'h022; rd_lo_i = 1;
    step();
    wr_valid_i = 0; rd_lo_i = 0;
    chk("R1 push+pop count", count_o, 1);
    chk("R2 push+pop head", head_data_o, 'h022);
    pop();
  endtask

  task automatic t_dready();
    dres_sel_i = 0;
    push(9'h0AA, 0, 0, 0);
    push(9'h0BB, 0, 0, 0);
    ticks(14);
    chk("R5 not yet", dready_o, 0);
    ticks(1);
    chk("R5 set at 15", dready_o, 1);
    chk("R8 sel0 rx", rx_irq_o, 1);
    chk("R8 sel0 err", err_irq_o, 0);
    dres_sel_i = 1; #1;
    chk("R8 sel1 rx", rx_irq_o, 0);
    chk("R8 sel1 err", err_irq_o, 1);
    dres_sel_i = 0;
    start_det_i = 1; step(); start_det_i = 0;
    chk("R5 start clears", dready_o, 0);
    ticks(20);
    chk("R5 not rearmed by start", dready_o, 0);
    push(9'h0CC, 0, 0, 0);
    ticks(15);
    chk("R5 set again", dready_o, 1);
    pop(); pop();
    chk("R5 held with one left", dready_o, 1);
    pop();
    chk("R5 cleared on empty", dready_o, 0);
    // above threshold: no data-ready
    for (int i = 0; i < 5; i++) push(9'(i), 0, 0, 0);
    ticks(15);
    chk("R5 above trig", dready_o, 0);
    fifo_clr_i = 1; step(); fifo_clr_i = 0;
  endtask

  task automatic t_overrun();
    for (int i = 0; i < DEPTH; i++) push(9'(i), 0, 0, logic'(i % 2));
    chk("R1 full", count_o, 16);
    chk("R6 no ovr yet", ovr_o, 0);
    push(9'h1FF, 0, 0, 0);
    chk("R6 count held", count_o, 16);
    chk("R6 ovr set", ovr_o, 1);
    chk("R8 err irq ovr", err_irq_o, 1);
    pop();
    chk("R6 ovr sticky", ovr_o, 1);
    chk("R2 order kept", head_data_o, 1);
    chk("R4 ferr 8", ferr_cnt_o, 8);
    fifo_clr_i = 1; step(); fifo_clr_i = 0;
    chk("R7 count cleared", count_o, 0);
    chk("R7 ferr cleared", ferr_cnt_o, 0);
    chk("R7 ovr kept", ovr_o, 1);
    ovr_clr_i = 1; step(); ovr_clr_i = 0;
    chk("R6 ovr cleared", ovr_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    step();
    t_reset();
    t_order();
    t_thresholds();
    t_same_cycle();
    t_dready();
    t_overrun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule